// File: doc/BRIEF.md
# Idle and Wake Sequencer

This block sits next to the fetch/execute stage of a small processor core. It watches the fetched 16-bit instruction word. When it sees the idle opcode, it parks the core in a low-power halted state. The halted flag doubles as the enable for gating the core clock. The block records where execution should resume and how many cycles the idle instruction cost. While the core is halted, the resume address does not move. Peripheral requests keep arriving during the halt, and the block keeps watching them.

The core wakes on one of three events: an enabled maskable request, the non-maskable request, or reset. What the core does next depends on the event and on the global interrupt-mode bit:

- A non-maskable wake always vectors to its own service routine.
- A maskable wake vectors only when the interrupt-mode bit is clear.
- With the interrupt-mode bit set, a maskable wake simply releases the core at the word after the idle.

When the block vectors, it emits a single-cycle take strobe with the source index and places the vector address on the next-PC output.

Top module: `idle_wake_seq`

## Requirements
- R1: A valid fetched word equal to 0xBE22 halts a running core at the next clock edge. Any other word, or the idle word without its valid strobe, leaves the core running.
- R2: On idle entry, `next_pc` becomes `cur_pc + 1`, wrapping modulo 2^PC_W.
- R3: While the core stays halted, `next_pc` does not change, and fetched words (including further idle words) are ignored.
- R4: While halted, any request that is both pending in `irq_req` and set in `irq_en` wakes the core whatever `intm` is. `halted` drops combinationally in the same cycle and stays low afterwards.
- R5: A request pending in `irq_req` whose `irq_en` bit is clear does not wake the core.
- R6: A maskable wake with `intm` = 0 pulses `take_irq` with `take_src` = source index. `next_pc` = VEC_BASE + VEC_STRIDE × index (default: 2 + 2 × index).
- R7: A maskable wake with `intm` = 1 leaves `take_irq` low, and `next_pc` stays at the word after the idle.
- R8: `nmi` always wakes a halted core and always vectors, whatever `intm` is, and it wins over maskable requests. `take_src` = N_IRQ (default 6), and `next_pc` = VEC_BASE + VEC_STRIDE × N_IRQ (default 14).
- R9: When several enabled maskable requests are pending together, the lowest index wins.
- R10: `take_irq` is high for exactly one cycle per wake.
- R11: `idle_cycles` holds the cost of the last idle: 1 when fetched on chip, and 1 + `wait_states` when `ext_fetch` is set.
- R12: Synchronous active-low reset wins over every other event. While `rst_n` is low, `take_irq` is 0. After the clock edge, `halted` = 0, `next_pc` = 0 and `idle_cycles` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, not gated |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Fetched word is valid this cycle |
| instr_word | input | 16 | Fetched instruction word |
| cur_pc | input | PC_W | Address of the fetched word |
| ext_fetch | input | 1 | Word came from external memory |
| wait_states | input | WS_W | External wait-state count |
| irq_req | input | N_IRQ | Pending maskable requests |
| irq_en | input | N_IRQ | Per-source enable mask |
| intm | input | 1 | Global interrupt-mode bit (1 = maskable vectoring disabled) |
| nmi | input | 1 | Non-maskable request |
| halted | output | 1 | Core halted; gates the core clock |
| next_pc | output | PC_W | Resume or vector address |
| take_irq | output | 1 | One-cycle vectoring strobe |
| take_src | output | $clog2(N_IRQ+1) | Winning source index (N_IRQ = non-maskable) |
| idle_cycles | output | WS_W+1 | Cycle cost of the last idle |

## Verification
The bench builds the block with N_IRQ = 6, PC_W = 16, WS_W = 4, VEC_BASE = 2 and VEC_STRIDE = 2.

With six sources, one run can cover all of the following: lowest-index arbitration across scattered requests, a fully pending but fully masked vector, and the highest source slot just below the non-maskable index. A 16-bit PC lets an idle at 0xFFFF exercise the wrap to zero. A 4-bit wait-state field reaches its maximum of 15, which gives a cost of 16 and fills the widened count output.

// File: rtl/idle_pkg.sv
// Shared constants and helpers for the idle/wake sequencer.
// Assumes a 16-bit instruction word.
package idle_pkg;
    localparam int unsigned INSTR_W = 16;
    localparam logic [INSTR_W-1:0] IDLE_OPCODE = 16'hBE22;

    // Compute the vector address for a source index.
    function automatic logic [31:0] vector_addr(input int unsigned base,
                                                input int unsigned stride,
                                                input int unsigned src);
        return 32'(base + stride * src);
    endfunction
endpackage

// File: rtl/idle_decode.sv
// Matches the idle opcode on a valid fetch and reports the cycle cost of
// the instruction: 1 on chip, 1 + wait states when fetched externally.
// Assumes wait_states is stable in the fetch cycle.
module idle_decode
    import idle_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               ext_fetch,
    input  logic [WS_W-1:0]    wait_states,
    output logic               is_idle,
    output logic [WS_W:0]      cost
);
    localparam int CW = WS_W + 1;

    // Opcode match and cost selection.
    always_comb begin
        is_idle = instr_valid && (instr_word == IDLE_OPCODE);
        cost    = ext_fetch ? (CW'(wait_states) + CW'(1)) : CW'(1);
    end
endmodule

// File: rtl/wake_arbiter.sv
// Picks the winning wake event among the non-maskable line and the
// enabled maskable requests. The non-maskable line wins first, then the
// lowest maskable index. The non-maskable source is reported as index N_IRQ.
// Purely combinational; assumes inputs are synchronous to the core clock.
module wake_arbiter #(
    parameter int N_IRQ = 6,
    localparam int SRC_W = $clog2(N_IRQ + 1)
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             nmi,
    output logic             any_event,
    output logic             is_nmi,
    output logic [SRC_W-1:0] src
);
    logic [N_IRQ-1:0] active;
    logic [N_IRQ-1:0] grant;
    logic [N_IRQ:0]   seen;

    assign active  = irq_req & irq_en;
    assign seen[0] = 1'b0;

    // Priority chain: a source is granted only if no lower index is active.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_chain
        assign grant[i]  = active[i] && !seen[i];
        assign seen[i+1] = seen[i] || active[i];
    end

    // Encode the winner; the non-maskable line overrides maskable grants.
    always_comb begin
        src = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (grant[i]) src = SRC_W'(i);
        end
        if (nmi) src = SRC_W'(N_IRQ);
        is_nmi    = nmi;
        any_event = nmi || seen[N_IRQ];
    end
endmodule

// File: rtl/idle_wake_seq.sv
// Idle and wake sequencer. It halts the core on the idle opcode, holds the
// resume address, and releases the core on an enabled maskable request,
// the non-maskable line, or reset.
// Vectoring happens on a non-maskable wake, or on a maskable wake with intm = 0.
// Assumes the halted output gates the core clock while this block stays clocked.
module idle_wake_seq
    import idle_pkg::*;
#(
    parameter int N_IRQ      = 6,
    parameter int PC_W       = 16,
    parameter int WS_W       = 4,
    parameter int VEC_BASE   = 2,
    parameter int VEC_STRIDE = 2,
    localparam int SRC_W     = $clog2(N_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic               ext_fetch,
    input  logic [WS_W-1:0]    wait_states,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    input  logic               intm,
    input  logic               nmi,
    output logic               halted,
    output logic [PC_W-1:0]    next_pc,
    output logic               take_irq,
    output logic [SRC_W-1:0]   take_src,
    output logic [WS_W:0]      idle_cycles
);
    logic             halted_q;
    logic [PC_W-1:0]  pc_q;
    logic [WS_W:0]    cyc_q;
    logic             dec_hit;
    logic [WS_W:0]    dec_cost;
    logic             ev_any;
    logic             ev_nmi;
    logic [SRC_W-1:0] ev_src;
    logic             wake;
    logic             take;
    logic [PC_W-1:0]  vec_pc;

    idle_decode #(.WS_W(WS_W)) u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .ext_fetch   (ext_fetch),
        .wait_states (wait_states),
        .is_idle     (dec_hit),
        .cost        (dec_cost)
    );

    wake_arbiter #(.N_IRQ(N_IRQ)) u_arb (
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .nmi       (nmi),
        .any_event (ev_any),
        .is_nmi    (ev_nmi),
        .src       (ev_src)
    );

    // Wake qualification; reset suppresses every other event.
    always_comb begin
        wake   = rst_n && halted_q && ev_any;
        take   = wake && (ev_nmi || !intm);
        vec_pc = PC_W'(vector_addr(VEC_BASE, VEC_STRIDE, 32'(ev_src)));
    end

    // Drive outputs; halted drops in the same cycle the wake is seen.
    always_comb begin
        halted      = halted_q && !wake;
        take_irq    = take;
        take_src    = take ? ev_src : '0;
        next_pc     = take ? vec_pc : pc_q;
        idle_cycles = cyc_q;
    end

    // Halt state, resume address and idle cost registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b0;
            pc_q     <= '0;
            cyc_q    <= '0;
        end else if (wake) begin
            halted_q <= 1'b0;
            if (take) pc_q <= vec_pc;
        end else if (!halted_q && dec_hit) begin
            halted_q <= 1'b1;
            pc_q     <= cur_pc + PC_W'(1);
            cyc_q    <= dec_cost;
        end
    end

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && dec_hit) |=> (halted_q && pc_q == PC_W'($past(cur_pc) + PC_W'(1)))); // R2
    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !wake) |=> $stable(pc_q)); // R3
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !halted_q); // R4
    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !nmi && ((irq_req & irq_en) == '0)) |-> halted); // R5
    AST_INTM_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && intm && !nmi) |-> !take_irq); // R7
    AST_NMI_VECTORS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && nmi) |-> (take_irq && take_src == SRC_W'(N_IRQ))); // R8
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!halted_q && pc_q == '0)); // R12
endmodule

// File: tb/idle_wake_seq_test.sv
module idle_wake_seq_test;
    localparam int N_IRQ = 6;
    localparam int PC_W  = 16;
    localparam int WS_W  = 4;

    typedef struct packed {
        logic [15:0] pc;
        logic [5:0]  req;
        logic [5:0]  en;
        logic        intm;
        logic        nmi;
        logic        ext;
        logic [3:0]  ws;
        logic        wk;
        logic        tk;
        logic [2:0]  src;
        logic [15:0] epc;
        logic [4:0]  cyc;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{16'h0010, 6'b000100, 6'b111111, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 3'd2, 16'h0006, 5'd1},
        '{16'h0020, 6'b000100, 6'b111111, 1'b1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0, 3'd0, 16'h0021, 5'd4},
        '{16'h0030, 6'b001000, 6'b110111, 1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 3'd0, 16'h0031, 5'd1},
        '{16'h0040, 6'b101010, 6'b111111, 1'b0, 1'b0, 1'b1, 4'd15, 1'b1, 1'b1, 3'd1, 16'h0004, 5'd16},
        '{16'h0050, 6'b000001, 6'b111111, 1'b1, 1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 3'd6, 16'h000E, 5'd1},
        '{16'h0060, 6'b000000, 6'b000000, 1'b1, 1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 3'd6, 16'h000E, 5'd1},
        '{16'hFFFF, 6'b100000, 6'b100000, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 3'd5, 16'h000C, 5'd1},
        '{16'h0070, 6'b111111, 6'b000000, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0, 16'h0071, 5'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [15:0]      instr_word = '0;
    logic [PC_W-1:0]  cur_pc = '0;
    logic             ext_fetch = 1'b0;
    logic [WS_W-1:0]  wait_states = '0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             intm = 1'b0;
    logic             nmi = 1'b0;
    logic             halted;
    logic [PC_W-1:0]  next_pc;
    logic             take_irq;
    logic [2:0]       take_src;
    logic [WS_W:0]    idle_cycles;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    idle_wake_seq #(.N_IRQ(N_IRQ), .PC_W(PC_W), .WS_W(WS_W),
                    .VEC_BASE(2), .VEC_STRIDE(2)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_word(instr_word), .cur_pc(cur_pc), .ext_fetch(ext_fetch),
        .wait_states(wait_states), .irq_req(irq_req), .irq_en(irq_en),
        .intm(intm), .nmi(nmi), .halted(halted), .next_pc(next_pc),
        .take_irq(take_irq), .take_src(take_src), .idle_cycles(idle_cycles)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic next_neg();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        irq_req = '0;
        irq_en = '0;
        nmi = 1'b0;
        next_neg();
        rst_n = 1'b1;
    endtask

    task automatic issue_idle(input logic [15:0] pc, input logic ext, input logic [3:0] ws);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word = 16'hBE22;
        cur_pc = pc;
        ext_fetch = ext;
        wait_states = ws;
        next_neg();
        instr_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R12: reset state
        do_reset();
        #1;
        chk("R12 halted after reset", 32'(halted), 0);
        chk("R12 next_pc after reset", 32'(next_pc), 0);
        chk("R12 take_irq after reset", 32'(take_irq), 0);
        chk("R12 idle_cycles after reset", 32'(idle_cycles), 0);

        // Table walk
        for (int k = 0; k < 8; k++) begin
            do_reset();
            intm = ROWS[k].intm;
            issue_idle(ROWS[k].pc, ROWS[k].ext, ROWS[k].ws);
            #1;
            chk("R1 halted on idle", 32'(halted), 1);
            chk("R2 next_pc after idle", 32'(next_pc), 32'(16'(ROWS[k].pc + 16'd1)));
            chk("R11 idle_cycles", 32'(idle_cycles), 32'(ROWS[k].cyc));
            irq_req = ROWS[k].req;
            irq_en = ROWS[k].en;
            nmi = ROWS[k].nmi;
            #1;
            chk("R4/R5 halted at wake", 32'(halted), 32'(!ROWS[k].wk));
            chk("R6/R7/R8 take_irq", 32'(take_irq), 32'(ROWS[k].tk));
            if (ROWS[k].tk) chk("R8/R9 take_src", 32'(take_src), 32'(ROWS[k].src));
            chk("R6/R7 next_pc at wake", 32'(next_pc), 32'(ROWS[k].epc));
            next_neg();
            irq_req = '0;
            irq_en = '0;
            nmi = 1'b0;
            #1;
            chk("R10 take_irq one cycle", 32'(take_irq), 0);
            chk("R4 halted after wake", 32'(halted), 32'(!ROWS[k].wk));
            chk("R3/R6 next_pc after wake", 32'(next_pc), 32'(ROWS[k].epc));
        end

        // R1: near-miss word and idle without valid strobe do not halt
        do_reset();
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word = 16'hBE23;
        cur_pc = 16'h0100;
        next_neg();
        instr_valid = 1'b0;
        instr_word = 16'hBE22;
        next_neg();
        #1;
        chk("R1 no halt on other word", 32'(halted), 0);
        chk("R1 next_pc untouched", 32'(next_pc), 0);

        // R3: idle words while halted are ignored
        issue_idle(16'h0200, 1'b0, 4'd0);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word = 16'hBE22;
        cur_pc = 16'h1234;
        ext_fetch = 1'b1;
        wait_states = 4'd7;
        next_neg();
        next_neg();
        instr_valid = 1'b0;
        #1;
        chk("R3 still halted", 32'(halted), 1);
        chk("R3 next_pc held", 32'(next_pc), 32'h0201);
        chk("R3 idle_cycles held", 32'(idle_cycles), 1);

        // R12: reset wins over a pending non-maskable request while halted
        @(negedge clk);
        intm = 1'b0;
        nmi = 1'b1;
        rst_n = 1'b0;
        #1;
        chk("R12 no take during reset", 32'(take_irq), 0);
        next_neg();
        #1;
        chk("R12 halted cleared by reset", 32'(halted), 0);
        chk("R12 next_pc zeroed by reset", 32'(next_pc), 0);
        rst_n = 1'b1;
        nmi = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule